// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of the cache misses that one bank has sent to memory and not yet seen answered. Each slot remembers which line missed (set index and line tag), whether the access was a write, which way was chosen as the victim, and who asked for it: one valid bit, one source id and one source tag per bank port. A fresh request is compared against every live slot in the same cycle. A match means the line is already being fetched (a secondary miss). No match means a primary miss, and only a primary miss raises a memory fill request. Its 32-bit tag tells the returning fill where to go.

When memory answers, the fill names the slot it belongs to (the root). The block then shows the bank which way to install, with the root's set and tag. It also flags every live slot that waits on the same line, so that all merged misses drain from one fill without further memory traffic. Flagged slots are handed back to the bank pipeline one per cycle, lowest index first, and each is freed as it is taken. Occupancy, full and empty are reported so that the bank can stall new misses before the file overflows.

Top module: `mshr_file`

## Requirements
- R1: After reset no slot is live: `occupancy` is 0, `empty` is 1, `full` is 0, `popValid` is 0 and `lkHit` is 0.
- R2: `lkHit` is 1 in the same cycle that some live slot holds a set index equal to `reqSet` and a line tag equal to `reqLineTag`. `lkIdx` is then the lowest such slot. A slot that matches on only one of the two fields does not hit. The lookup does not depend on `reqValid`.
- R3: `allocIdx` shows the lowest-indexed free slot. When `reqValid` is 1 the request is written into that slot at the next clock edge, with its replay flag cleared, and `occupancy` rises by one.
- R4: `memReqValid` is 1 only in a cycle where a request is allocated and `lkHit` is 0. `memReqTag[15:0]` then holds the `BANK_ID` parameter and `memReqTag[31:16]` holds `allocIdx`.
- R5: `full` is 1 exactly when `occupancy` equals `ENTRIES`, and `empty` is 1 exactly when it is 0. Allocating while `full` is 1 is a protocol violation that an assertion flags.
- R6: A fill (`fillValid` with `fillIdx` naming a live slot) sets the replay flag, at the next edge, of every live slot whose set and tag both equal the root's. Slots on other lines are left as they were.
- R7: In the cycle of a fill to a live slot, `instValid` is 1 and `instSet`, `instWay` and `instLineTag` carry the root's set, recorded victim way and tag.
- R8: `popValid` is 1 whenever some live slot is flagged for replay. `popIdx` is then the lowest such slot, and the `pop*` outputs carry its stored tag and its requester info. With `popReady` at 1 that slot is freed at the next edge and `occupancy` falls by one.
- R9: An allocation and a pop in the same cycle leave `occupancy` unchanged.
- R10: A request allocated in the same cycle as a fill for the same set and tag is flagged for replay at once, so it cannot be stranded behind a fill that has already arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Allocate the presented miss |
| reqSet | input | SET_W | Set index of the miss (also the lookup key) |
| reqLineTag | input | TAG_W | Line tag of the miss (also the lookup key) |
| reqWrite | input | 1 | Miss is a write |
| reqWay | input | WAY_W | Victim way chosen for the line |
| reqPortValid | input | PORTS | Per-port requester valid |
| reqSrcId | input | PORTS*SRCID_W | Per-port requester id |
| reqSrcTag | input | PORTS*SRCTAG_W | Per-port requester tag |
| fillValid | input | 1 | Memory fill returned |
| fillIdx | input | IDX_W | Slot named by the fill |
| popReady | input | 1 | Bank takes the presented replay |
| lkHit | output | 1 | Request line already pending |
| lkIdx | output | IDX_W | Lowest matching slot |
| allocIdx | output | IDX_W | Lowest free slot |
| memReqValid | output | 1 | Issue a memory fill request |
| memReqTag | output | 32 | Fill routing tag (bank, slot) |
| full | output | 1 | All slots live |
| empty | output | 1 | No slot live |
| occupancy | output | CNT_W | Number of live slots |
| popValid | output | 1 | A replay is ready |
| popIdx | output | IDX_W | Slot being replayed |
| popSet | output | SET_W | Replayed set index |
| popLineTag | output | TAG_W | Replayed line tag |
| popWrite | output | 1 | Replayed write flag |
| popWay | output | WAY_W | Replayed victim way |
| popPortValid | output | PORTS | Replayed per-port valid |
| popSrcId | output | PORTS*SRCID_W | Replayed requester ids |
| popSrcTag | output | PORTS*SRCTAG_W | Replayed requester tags |
| instValid | output | 1 | Install a line in the cache |
| instSet | output | SET_W | Set to install |
| instWay | output | WAY_W | Way to install |
| instLineTag | output | TAG_W | Tag to install |

## Verification
The hardest case to reach from the ports is a fill landing in the same cycle as a new secondary miss for the same line. The new slot must come out already flagged, while a neighbour in the same set with a different tag stays unflagged. The vector table builds this state on purpose. It fills the file, drains part of it with a pop that overlaps an allocation, and then drives a matching request together with the fill of its root. Later rows show the merged slot popping straight away and the other-tag slot staying silent until its own fill arrives.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

  // Field split of the outgoing memory tag: bank id below, slot index above.
  localparam int MEMTAG_HALF_W = 16;

  // Strobes the control issues to the storage each cycle.
  typedef struct packed {
    logic allocEn;   // write the request into the chosen free slot
    logic popEn;     // free the chosen replay slot
    logic fillEn;    // a fill names a root slot this cycle
  } mshrStrobe_t;

endpackage

// File: rtl/mshr_datapath.sv
module mshr_datapath
  import mshr_pkg::*;
#(
  parameter int ENTRIES  = 4,
  parameter int SET_W    = 4,
  parameter int TAG_W    = 8,
  parameter int WAY_W    = 2,
  parameter int PORTS    = 2,
  parameter int SRCID_W  = 3,
  parameter int SRCTAG_W = 8,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  mshrStrobe_t                strb,
  input  logic [IDX_W-1:0]           allocIdx,
  input  logic [IDX_W-1:0]           popIdx,
  input  logic [IDX_W-1:0]           fillIdx,
  input  logic [SET_W-1:0]           reqSet,
  input  logic [TAG_W-1:0]           reqLineTag,
  input  logic                       reqWrite,
  input  logic [WAY_W-1:0]           reqWay,
  input  logic [PORTS-1:0]           reqPortValid,
  input  logic [PORTS*SRCID_W-1:0]   reqSrcId,
  input  logic [PORTS*SRCTAG_W-1:0]  reqSrcTag,
  output logic [ENTRIES-1:0]         validVec,
  output logic [ENTRIES-1:0]         replayVec,
  output logic [ENTRIES-1:0]         matchVec,
  output logic [SET_W-1:0]           popSet,
  output logic [TAG_W-1:0]           popLineTag,
  output logic                       popWrite,
  output logic [WAY_W-1:0]           popWay,
  output logic [PORTS-1:0]           popPortValid,
  output logic [PORTS*SRCID_W-1:0]   popSrcId,
  output logic [PORTS*SRCTAG_W-1:0]  popSrcTag,
  output logic                       instValid,
  output logic [SET_W-1:0]           instSet,
  output logic [WAY_W-1:0]           instWay,
  output logic [TAG_W-1:0]           instLineTag
);

  // Per-slot state: valid/replay under reset, payload loaded on allocation.
  logic [ENTRIES-1:0]        validQ, replayQ;
  logic [SET_W-1:0]          entSet     [ENTRIES];
  logic [TAG_W-1:0]          entTag     [ENTRIES];
  logic                      entWrite   [ENTRIES];
  logic [WAY_W-1:0]          entWay     [ENTRIES];
  logic [PORTS-1:0]          entPortV   [ENTRIES];
  logic [PORTS*SRCID_W-1:0]  entSrcId   [ENTRIES];
  logic [PORTS*SRCTAG_W-1:0] entSrcTag  [ENTRIES];

  // Root of the current fill.
  logic [SET_W-1:0] rootSet;
  logic [TAG_W-1:0] rootTag;
  logic [WAY_W-1:0] rootWay;
  logic             rootLive;
  logic             allocOnRoot;

  assign rootSet  = entSet[fillIdx];
  assign rootTag  = entTag[fillIdx];
  assign rootWay  = entWay[fillIdx];
  assign rootLive = strb.fillEn && validQ[fillIdx];

  // A request merging onto a line whose fill lands this very cycle.
  assign allocOnRoot = rootLive && (reqSet == rootSet) && (reqLineTag == rootTag);

  // Per-slot decode: lookup match, fill sibling, allocation and pop selects.
  logic [ENTRIES-1:0] sameLine, allocSel, popSel;

  for (genvar i = 0; i < ENTRIES; i++) begin : gSlot
    assign matchVec[i] = validQ[i] && (entSet[i] == reqSet) && (entTag[i] == reqLineTag);
    assign sameLine[i] = validQ[i] && (entSet[i] == rootSet) && (entTag[i] == rootTag);
    assign allocSel[i] = strb.allocEn && (allocIdx == IDX_W'(i));
    assign popSel[i]   = strb.popEn   && (popIdx   == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ  <= '0;
      replayQ <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (allocSel[i]) begin
          validQ[i]  <= 1'b1;
          replayQ[i] <= allocOnRoot;
        end else if (popSel[i]) begin
          validQ[i]  <= 1'b0;
          replayQ[i] <= 1'b0;
        end else if (rootLive && sameLine[i]) begin
          replayQ[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (allocSel[i]) begin
        entSet[i]    <= reqSet;
        entTag[i]    <= reqLineTag;
        entWrite[i]  <= reqWrite;
        entWay[i]    <= reqWay;
        entPortV[i]  <= reqPortValid;
        entSrcId[i]  <= reqSrcId;
        entSrcTag[i] <= reqSrcTag;
      end
    end
  end

  assign validVec  = validQ;
  assign replayVec = replayQ;

  // Replay payload of the slot the control selected.
  assign popSet       = entSet[popIdx];
  assign popLineTag   = entTag[popIdx];
  assign popWrite     = entWrite[popIdx];
  assign popWay       = entWay[popIdx];
  assign popPortValid = entPortV[popIdx];
  assign popSrcId     = entSrcId[popIdx];
  assign popSrcTag    = entSrcTag[popIdx];

  // Line install for the cache arrays.
  assign instValid   = rootLive;
  assign instSet     = rootSet;
  assign instWay     = rootWay;
  assign instLineTag = rootTag;

  // R3: allocation only ever lands in a free slot and makes it live.
  a_r3_alloc_into_free: assert property (@(posedge clk) disable iff (!rstN)
    strb.allocEn |-> !validQ[allocIdx]);
  a_r3_alloc_goes_live: assert property (@(posedge clk) disable iff (!rstN)
    strb.allocEn |=> validQ[$past(allocIdx)]);
  // R8: a pop frees the slot it took.
  a_r8_pop_frees: assert property (@(posedge clk) disable iff (!rstN)
    strb.popEn |=> !validQ[$past(popIdx)]);
  // R6: a replay flag never survives on a free slot.
  a_r6_flag_on_live: assert property (@(posedge clk) disable iff (!rstN)
    (replayQ & ~validQ) == '0);

endmodule

// File: rtl/mshr_ctrl.sv
module mshr_ctrl
  import mshr_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               fillValid,
  input  logic               popReady,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] replayVec,
  input  logic [ENTRIES-1:0] matchVec,
  output mshrStrobe_t        strb,
  output logic [IDX_W-1:0]   allocIdx,
  output logic [IDX_W-1:0]   popIdx,
  output logic [IDX_W-1:0]   lkIdx,
  output logic               lkHit,
  output logic               primaryMiss,
  output logic               popValid,
  output logic               full,
  output logic               empty,
  output logic [CNT_W-1:0]   occupancy
);

  logic [CNT_W-1:0]   occQ;
  logic [ENTRIES-1:0] readyVec;

  assign readyVec = validVec & replayVec;

  // Lowest-index pickers: scan down so the lowest set bit wins.
  always_comb begin
    allocIdx = '0;
    popIdx   = '0;
    lkIdx    = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) allocIdx = IDX_W'(i);
      if (readyVec[i])  popIdx   = IDX_W'(i);
      if (matchVec[i])  lkIdx    = IDX_W'(i);
    end
  end

  assign lkHit    = |matchVec;
  assign popValid = |readyVec;
  assign full     = (occQ == CNT_W'(ENTRIES));
  assign empty    = (occQ == '0);

  assign strb.allocEn = reqValid && !full;
  assign strb.popEn   = popValid && popReady;
  assign strb.fillEn  = fillValid;

  assign primaryMiss = strb.allocEn && !lkHit;

  always_ff @(posedge clk) begin
    if (!rstN) occQ <= '0;
    else       occQ <= occQ + CNT_W'(strb.allocEn) - CNT_W'(strb.popEn);
  end

  assign occupancy = occQ;

  // R5: allocating into a full file is illegal.
  a_r5_no_alloc_when_full: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !full);
  // R9: the running count always agrees with the number of live slots.
  a_r9_count_tracks: assert property (@(posedge clk) disable iff (!rstN)
    int'(occQ) == $countones(validVec));
  // R4: a request that merged onto a pending line never goes to memory.
  a_r4_merge_silent: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && |(matchVec)) |-> !primaryMiss);

endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int ENTRIES  = 4,
  parameter int SET_W    = 4,
  parameter int TAG_W    = 8,
  parameter int WAY_W    = 2,
  parameter int PORTS    = 2,
  parameter int SRCID_W  = 3,
  parameter int SRCTAG_W = 8,
  parameter int BANK_ID  = 5,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [SET_W-1:0]           reqSet,
  input  logic [TAG_W-1:0]           reqLineTag,
  input  logic                       reqWrite,
  input  logic [WAY_W-1:0]           reqWay,
  input  logic [PORTS-1:0]           reqPortValid,
  input  logic [PORTS*SRCID_W-1:0]   reqSrcId,
  input  logic [PORTS*SRCTAG_W-1:0]  reqSrcTag,
  input  logic                       fillValid,
  input  logic [IDX_W-1:0]           fillIdx,
  input  logic                       popReady,
  output logic                       lkHit,
  output logic [IDX_W-1:0]           lkIdx,
  output logic [IDX_W-1:0]           allocIdx,
  output logic                       memReqValid,
  output logic [31:0]                memReqTag,
  output logic                       full,
  output logic                       empty,
  output logic [CNT_W-1:0]           occupancy,
  output logic                       popValid,
  output logic [IDX_W-1:0]           popIdx,
  output logic [SET_W-1:0]           popSet,
  output logic [TAG_W-1:0]           popLineTag,
  output logic                       popWrite,
  output logic [WAY_W-1:0]           popWay,
  output logic [PORTS-1:0]           popPortValid,
  output logic [PORTS*SRCID_W-1:0]   popSrcId,
  output logic [PORTS*SRCTAG_W-1:0]  popSrcTag,
  output logic                       instValid,
  output logic [SET_W-1:0]           instSet,
  output logic [WAY_W-1:0]           instWay,
  output logic [TAG_W-1:0]           instLineTag
);

  mshrStrobe_t        strb;
  logic [ENTRIES-1:0] validVec, replayVec, matchVec;

  mshr_ctrl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .fillValid   (fillValid),
    .popReady    (popReady),
    .validVec    (validVec),
    .replayVec   (replayVec),
    .matchVec    (matchVec),
    .strb        (strb),
    .allocIdx    (allocIdx),
    .popIdx      (popIdx),
    .lkIdx       (lkIdx),
    .lkHit       (lkHit),
    .primaryMiss (memReqValid),
    .popValid    (popValid),
    .full        (full),
    .empty       (empty),
    .occupancy   (occupancy)
  );

  mshr_datapath #(
    .ENTRIES(ENTRIES), .SET_W(SET_W), .TAG_W(TAG_W), .WAY_W(WAY_W),
    .PORTS(PORTS), .SRCID_W(SRCID_W), .SRCTAG_W(SRCTAG_W)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .allocIdx     (allocIdx),
    .popIdx       (popIdx),
    .fillIdx      (fillIdx),
    .reqSet       (reqSet),
    .reqLineTag   (reqLineTag),
    .reqWrite     (reqWrite),
    .reqWay       (reqWay),
    .reqPortValid (reqPortValid),
    .reqSrcId     (reqSrcId),
    .reqSrcTag    (reqSrcTag),
    .validVec     (validVec),
    .replayVec    (replayVec),
    .matchVec     (matchVec),
    .popSet       (popSet),
    .popLineTag   (popLineTag),
    .popWrite     (popWrite),
    .popWay       (popWay),
    .popPortValid (popPortValid),
    .popSrcId     (popSrcId),
    .popSrcTag    (popSrcTag),
    .instValid    (instValid),
    .instSet      (instSet),
    .instWay      (instWay),
    .instLineTag  (instLineTag)
  );

  // Routing tag for the fill: bank id in the low half, slot index in the high half.
  assign memReqTag = {MEMTAG_HALF_W'(allocIdx), MEMTAG_HALF_W'(BANK_ID)};

endmodule

// File: tb/test_mshr_file.sv
`timescale 1ns/1ps
module test_mshr_file;

  localparam int BANK = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [3:0]  reqSet = '0;
  logic [7:0]  reqLineTag = '0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqWay = '0;
  logic [1:0]  reqPortValid = '0;
  logic [5:0]  reqSrcId = '0;
  logic [15:0] reqSrcTag = '0;
  logic        fillValid = 1'b0;
  logic [1:0]  fillIdx = '0;
  logic        popReady = 1'b0;

  logic        lkHit, memReqValid, full, empty, popValid, popWrite, instValid;
  logic [1:0]  lkIdx, allocIdx, popIdx, popWay, popPortValid, instWay;
  logic [31:0] memReqTag;
  logic [2:0]  occupancy;
  logic [3:0]  popSet, instSet;
  logic [7:0]  popLineTag, instLineTag;
  logic [5:0]  popSrcId;
  logic [15:0] popSrcTag;

  always #2.5 clk = ~clk;

  mshr_file #(.BANK_ID(BANK)) i_mshr_file (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSet(reqSet),
    .reqLineTag(reqLineTag), .reqWrite(reqWrite), .reqWay(reqWay),
    .reqPortValid(reqPortValid), .reqSrcId(reqSrcId), .reqSrcTag(reqSrcTag),
    .fillValid(fillValid), .fillIdx(fillIdx), .popReady(popReady),
    .lkHit(lkHit), .lkIdx(lkIdx), .allocIdx(allocIdx),
    .memReqValid(memReqValid), .memReqTag(memReqTag), .full(full),
    .empty(empty), .occupancy(occupancy), .popValid(popValid),
    .popIdx(popIdx), .popSet(popSet), .popLineTag(popLineTag),
    .popWrite(popWrite), .popWay(popWay), .popPortValid(popPortValid),
    .popSrcId(popSrcId), .popSrcTag(popSrcTag), .instValid(instValid),
    .instSet(instSet), .instWay(instWay), .instLineTag(instLineTag)
  );

  int nChecks = 0;
  int nFail   = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One row: stimulus, then expected outputs seen before the clock edge.
  typedef struct packed {
    logic       a;     logic [3:0] s;  logic [7:0] t;
    logic       f;     logic [1:0] fi; logic       p;
    logic       eHit;  logic [1:0] eIdx; logic     eMem;
    logic       ePopV; logic [1:0] ePopIdx; logic [7:0] ePt;
    logic [2:0] eCnt;  logic [3:0] eFs; logic [7:0] eFt;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    //  a  s    t      f  fi   p  hit idx  mem popV pIdx pt    cnt  fs   ft
    '{1'b1,4'd1,8'd10,1'b0,2'd0,1'b0,1'b0,2'd0,1'b1,1'b0,2'd0,8'd0, 3'd0,4'd0,8'd0 },  // primary
    '{1'b1,4'd1,8'd10,1'b0,2'd0,1'b0,1'b1,2'd1,1'b0,1'b0,2'd0,8'd0, 3'd1,4'd0,8'd0 },  // secondary
    '{1'b1,4'd2,8'd20,1'b0,2'd0,1'b0,1'b0,2'd2,1'b1,1'b0,2'd0,8'd0, 3'd2,4'd0,8'd0 },
    '{1'b1,4'd1,8'd11,1'b0,2'd0,1'b0,1'b0,2'd3,1'b1,1'b0,2'd0,8'd0, 3'd3,4'd0,8'd0 },  // same set, other tag
    '{1'b0,4'd0,8'd0, 1'b1,2'd0,1'b0,1'b0,2'd0,1'b0,1'b0,2'd0,8'd0, 3'd4,4'd1,8'd10},  // fill slot 0
    '{1'b0,4'd0,8'd0, 1'b0,2'd0,1'b1,1'b0,2'd0,1'b0,1'b1,2'd0,8'd10,3'd4,4'd0,8'd0 },
    '{1'b1,4'd3,8'd30,1'b0,2'd0,1'b1,1'b0,2'd0,1'b1,1'b1,2'd1,8'd10,3'd3,4'd0,8'd0 },  // alloc + pop
    '{1'b0,4'd0,8'd0, 1'b0,2'd0,1'b0,1'b0,2'd0,1'b0,1'b0,2'd0,8'd0, 3'd3,4'd0,8'd0 },
    '{1'b1,4'd2,8'd20,1'b1,2'd2,1'b0,1'b1,2'd1,1'b0,1'b0,2'd0,8'd0, 3'd3,4'd2,8'd20},  // alloc on filled line
    '{1'b0,4'd0,8'd0, 1'b0,2'd0,1'b1,1'b0,2'd0,1'b0,1'b1,2'd1,8'd20,3'd4,4'd0,8'd0 },
    '{1'b0,4'd0,8'd0, 1'b0,2'd0,1'b1,1'b0,2'd0,1'b0,1'b1,2'd2,8'd20,3'd3,4'd0,8'd0 },
    '{1'b0,4'd0,8'd0, 1'b0,2'd0,1'b1,1'b0,2'd0,1'b0,1'b0,2'd0,8'd0, 3'd2,4'd0,8'd0 },  // other tag untouched
    '{1'b0,4'd0,8'd0, 1'b1,2'd3,1'b0,1'b0,2'd0,1'b0,1'b0,2'd0,8'd0, 3'd2,4'd1,8'd11},
    '{1'b0,4'd0,8'd0, 1'b0,2'd0,1'b1,1'b0,2'd0,1'b0,1'b1,2'd3,8'd11,3'd2,4'd0,8'd0 },
    '{1'b0,4'd0,8'd0, 1'b1,2'd0,1'b0,1'b0,2'd0,1'b0,1'b0,2'd0,8'd0, 3'd1,4'd3,8'd30},
    '{1'b0,4'd0,8'd0, 1'b0,2'd0,1'b1,1'b0,2'd0,1'b0,1'b1,2'd0,8'd30,3'd1,4'd0,8'd0 },
    '{1'b0,4'd0,8'd0, 1'b0,2'd0,1'b0,1'b0,2'd0,1'b0,1'b0,2'd0,8'd0, 3'd0,4'd0,8'd0 }
  };

  task automatic idleInputs();
    reqValid = 1'b0; fillValid = 1'b0; popReady = 1'b0;
  endtask

  task automatic checkReset(input string tag);
    chk({"R1 occupancy ", tag}, 32'(occupancy), 32'd0);
    chk({"R1 empty ", tag},     32'(empty),     32'd1);
    chk({"R1 full ", tag},      32'(full),      32'd0);
    chk({"R1 popValid ", tag},  32'(popValid),  32'd0);
    chk({"R1 lkHit ", tag},     32'(lkHit),     32'd0);
  endtask

  initial begin
    #1_000_000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    reqSet = 4'd1; reqLineTag = 8'd10;  // lookup key present during reset
    #1 checkReset("in reset");
    rstN = 1'b1;
    @(negedge clk);
    #1 checkReset("after release");

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      reqValid     = VECS[v].a;
      reqSet       = VECS[v].s;
      reqLineTag   = VECS[v].t;
      reqWrite     = VECS[v].s[0];
      reqWay       = VECS[v].t[1:0];
      reqPortValid = 2'b01;
      reqSrcId     = {3'd0, VECS[v].s[2:0]};
      reqSrcTag    = {VECS[v].t, VECS[v].t ^ 8'hA5};
      fillValid    = VECS[v].f;
      fillIdx      = VECS[v].fi;
      popReady     = VECS[v].p;
      #1;
      if (VECS[v].a) begin
        chk($sformatf("R2 lkHit row %0d", v), 32'(lkHit), 32'(VECS[v].eHit));
        chk($sformatf("R3 allocIdx row %0d", v), 32'(allocIdx), 32'(VECS[v].eIdx));
      end
      chk($sformatf("R4 memReqValid row %0d", v), 32'(memReqValid), 32'(VECS[v].eMem));
      if (VECS[v].eMem)
        chk($sformatf("R4 memReqTag row %0d", v), memReqTag,
            {16'(VECS[v].eIdx), 16'(BANK)});
      chk($sformatf("R9 occupancy row %0d", v), 32'(occupancy), 32'(VECS[v].eCnt));
      chk($sformatf("R5 full row %0d", v),  32'(full),  32'(VECS[v].eCnt == 3'd4));
      chk($sformatf("R5 empty row %0d", v), 32'(empty), 32'(VECS[v].eCnt == 3'd0));
      chk($sformatf("R8 popValid row %0d", v), 32'(popValid), 32'(VECS[v].ePopV));
      if (VECS[v].ePopV) begin
        chk($sformatf("R8 popIdx row %0d", v), 32'(popIdx), 32'(VECS[v].ePopIdx));
        chk($sformatf("R8 popLineTag row %0d", v), 32'(popLineTag), 32'(VECS[v].ePt));
        chk($sformatf("R8 popSrcTag row %0d", v), 32'(popSrcTag),
            32'({VECS[v].ePt, VECS[v].ePt ^ 8'hA5}));
      end
      chk($sformatf("R7 instValid row %0d", v), 32'(instValid), 32'(VECS[v].f));
      if (VECS[v].f) begin
        chk($sformatf("R7 instSet row %0d", v), 32'(instSet), 32'(VECS[v].eFs));
        chk($sformatf("R7 instLineTag row %0d", v), 32'(instLineTag), 32'(VECS[v].eFt));
        chk($sformatf("R7 instWay row %0d", v), 32'(instWay), 32'(VECS[v].eFt[1:0]));
      end
    end

    // R6/R10: the row-8 merge popped right after its fill (rows 9, 10); the
    // other-tag slot stayed unflagged until its own fill (rows 11, 12).

    // R2: lookup needs both fields, and works without reqValid.
    @(negedge clk);
    idleInputs();
    reqValid = 1'b1; reqSet = 4'd5; reqLineTag = 8'd40; reqWay = 2'd0;
    #1 chk("R3 allocIdx directed", 32'(allocIdx), 32'd0);
    @(negedge clk);
    reqValid = 1'b0; reqSet = 4'd6; reqLineTag = 8'd40;
    #1 chk("R2 set differs -> miss", 32'(lkHit), 32'd0);
    @(negedge clk);
    reqSet = 4'd5; reqLineTag = 8'd41;
    #1 chk("R2 tag differs -> miss", 32'(lkHit), 32'd0);
    @(negedge clk);
    reqSet = 4'd5; reqLineTag = 8'd40;
    #1 chk("R2 both match -> hit", 32'(lkHit), 32'd1);
    chk("R2 lkIdx", 32'(lkIdx), 32'd0);
    chk("R4 no request without reqValid", 32'(memReqValid), 32'd0);

    // R6: a fill to a free slot changes nothing.
    @(negedge clk);
    fillValid = 1'b1; fillIdx = 2'd2;
    #1 chk("R7 fill to free slot no install", 32'(instValid), 32'd0);
    @(negedge clk);
    fillValid = 1'b0;
    #1 chk("R6 no replay from free-slot fill", 32'(popValid), 32'd0);

    // R1: reset in mid-run empties the file.
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    #1 checkReset("mid-run");

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule